// File: doc/BRIEF.md
# Timestamped change-event cluster packer

The packer sits between a sampled input port and a sample store. On every sample tick it takes one sample word and folds it, together with the samples before it, into a 16-bit event word. Depending on the packing mode, one event word holds one sample of all channels, two samples of half the channels, or four samples of a quarter of the channels. For the denser modes the samples are bit-interleaved rather than placed in contiguous fields. A timestamp counts completed event words. It runs freely from reset and wraps at its width.

Event words are stored only when they carry news. When an event word differs from the last stored one, the block opens a cluster: a timestamp word followed by seven event words, each one event period after the one before it. Stored words form a linear address sequence made of a row field in the upper bits and a word-in-row field in the lower bits. The address wraps after the last row, so the store behaves as a ring. If the input stays constant for a whole timestamp period, a cluster is opened anyway so that a reader can track timestamp rollover. A capture-enable input decides whether new clusters may open.

The control is a three-state machine. S_IDLE waits for an event word. The transition "open" goes to S_LEAD: the timestamp word is written and the first event is held. S_LEAD always advances to S_FILL, writing the held event. S_FILL writes each following event word, staying in S_FILL until the seventh event of the cluster is written, then returns to S_IDLE on "close".

Top module: `cpk_cluster_packer`

## Requirements
- R1: After reset, wr_en, wr_addr and wr_data are all zero. The timestamp is zero, and the last stored event word counts as zero.
- R2: mode encodes the packing. 0 and 3 give one sample per word (bit c equals channel c). 1 gives two samples of 8 channels. 2 gives four samples of 4 channels. With N samples per word, channel c of the k-th tick of the word (k counted from 0) lands on bit c*N+k. Input bits above channel 16/N-1 are ignored.
- R3: The timestamp counts completed event words from 0, wraps at 2^TS_W, and keeps counting while cap_en is low. A timestamp word carries the count of the word that opened the cluster, zero-extended.
- R4: In S_IDLE, a completed event word that differs from the last stored event word, with cap_en high, opens a cluster.
- R5: A cluster is written as the timestamp word followed by seven event words: the opening word and the next six completed words, in order, even if they repeat. Each write comes one cycle after the previous write or completed word, with wr_en high for one cycle per word.
- R6: While no cluster is open and event words equal the last stored event word, nothing is written.
- R7: With cap_en high, a cluster is also opened when 2^TS_W-1 event words have completed since the last cluster opened (or since reset). The timestamps of two consecutive clusters therefore differ by at most 2^TS_W-1.
- R8: Each write uses the next linear address {row, word}. The first write after reset goes to 0, and the address wraps to 0 after row 2^ROW_BITS-1, word 2^WORD_BITS-1.
- R9: cap_en is looked at in the cycle after the tick that completes an event word. While it is low, no cluster opens and no write occurs once an open cluster has finished. An already open cluster always completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe; sample_in is taken when high |
| sample_in | input | SAMPLE_W (16) | Channel levels for this sample |
| mode | input | 2 | Packing mode (see R2) |
| cap_en | input | 1 | Allows new clusters to open |
| wr_en | output | 1 | Store write strobe |
| wr_addr | output | ROW_BITS+WORD_BITS (24) | Store address: row in upper bits, word in lower bits |
| wr_data | output | SAMPLE_W (16) | Timestamp or event word |

## Verification
The assertions rely on tick never being high in two consecutive cycles. Under that rule, a cluster's lead cycle can never coincide with a newly completed event word. They also rely on mode staying constant between resets, and on cap_en holding from a completing tick through the following cycle. The bench drives every tick as a one-cycle pulse followed by at least one quiet cycle. It changes mode only while reset is held, and it changes cap_en only together with a tick and keeps it for the whole word. A reduced configuration (5-bit timestamp, 4 rows of 16 words) is used so that forced clusters and address wrap occur many times within each mode.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef enum logic [1:0] {
        PACK_X1   = 2'd0,
        PACK_X2   = 2'd1,
        PACK_X4   = 2'd2,
        PACK_X1B  = 2'd3
    } pack_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LEAD = 2'd1,
        S_FILL = 2'd2
    } clu_state_e;

    // index of the final sample lane in one event word
    function automatic logic [1:0] final_lane(input pack_mode_e m);
        logic [1:0] r;
        unique case (m)
            PACK_X2: r = 2'd1;
            PACK_X4: r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpk_lane_packer.sv
module cpk_lane_packer
    import cpk_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SAMPLE_W-1:0] sample,
    input  pack_mode_e          mode,
    output logic                word_vld,
    output logic [SAMPLE_W-1:0] word
);

    localparam int CH_X2 = SAMPLE_W / 2;
    localparam int CH_X4 = SAMPLE_W / 4;

    logic [1:0]          lane_q;
    logic [1:0]          lane_last;
    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] spread;
    logic [SAMPLE_W-1:0] merged;

    assign lane_last = final_lane(mode);

    // place this sample's channels on their interleaved bit positions
    always_comb begin
        spread = '0;
        unique case (mode)
            PACK_X2: begin
                for (int c = 0; c < CH_X2; c++) begin
                    spread[c*2 + int'(lane_q[0])] = sample[c];
                end
            end
            PACK_X4: begin
                for (int c = 0; c < CH_X4; c++) begin
                    spread[c*4 + int'(lane_q)] = sample[c];
                end
            end
            default: spread = sample;
        endcase
    end

    assign merged = ((lane_q == 2'd0) ? '0 : acc_q) | spread;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q   <= 2'd0;
            acc_q    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (tick) begin
                if (lane_q == lane_last) begin
                    word     <= merged;
                    word_vld <= 1'b1;
                    lane_q   <= 2'd0;
                    acc_q    <= '0;
                end else begin
                    acc_q  <= merged;
                    lane_q <= lane_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/cpk_timebase.sv
module cpk_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_vld,
    input  logic            open_hit,
    output logic [TS_W-1:0] ts,
    output logic            force_due
);

    localparam logic [TS_W-1:0] GAP_MAX = '1;

    logic [TS_W-1:0] gap_q;

    assign force_due = (gap_q == GAP_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts    <= '0;
            gap_q <= TS_W'(1);
        end else if (word_vld) begin
            ts <= ts + 1'b1;
            if (open_hit) begin
                gap_q <= TS_W'(1);
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpk_addr_gen.sv
module cpk_addr_gen #(
    parameter int ROW_BITS  = 15,
    parameter int WORD_BITS = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    output logic [ROW_BITS+WORD_BITS-1:0] addr
);

    logic [ROW_BITS-1:0]  row_q;
    logic [WORD_BITS-1:0] col_q;

    assign addr = {row_q, col_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (adv) begin
            col_q <= col_q + 1'b1;
            if (col_q == '1) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpk_cluster_packer.sv
module cpk_cluster_packer
    import cpk_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int TS_W      = 16,
    parameter int EVENTS    = 7,
    parameter int ROW_BITS  = 15,
    parameter int WORD_BITS = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [SAMPLE_W-1:0]           sample_in,
    input  logic [1:0]                    mode,
    input  logic                          cap_en,
    output logic                          wr_en,
    output logic [ROW_BITS+WORD_BITS-1:0] wr_addr,
    output logic [SAMPLE_W-1:0]           wr_data
);

    localparam int ADDR_W = ROW_BITS + WORD_BITS;
    localparam int SLOT_W = $clog2(EVENTS + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(EVENTS - 1);

    clu_state_e          state_q, state_d;
    logic [SLOT_W-1:0]   slot_q;
    logic [SAMPLE_W-1:0] last_q;
    logic [SAMPLE_W-1:0] hold_q;
    logic                word_vld;
    logic [SAMPLE_W-1:0] word;
    logic [TS_W-1:0]     ts;
    logic                force_due;
    logic [ADDR_W-1:0]   addr;
    logic [SAMPLE_W-1:0] stamp_ext;
    logic                open_hit;
    logic                fill_hit;
    logic                wr_fire;

    cpk_lane_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sample   (sample_in),
        .mode     (pack_mode_e'(mode)),
        .word_vld (word_vld),
        .word     (word)
    );

    cpk_timebase #(.TS_W(TS_W)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .open_hit  (open_hit),
        .ts        (ts),
        .force_due (force_due)
    );

    cpk_addr_gen #(.ROW_BITS(ROW_BITS), .WORD_BITS(WORD_BITS)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (wr_fire),
        .addr  (addr)
    );

    always_comb begin
        stamp_ext = '0;
        stamp_ext[TS_W-1:0] = ts;
    end

    assign open_hit = (state_q == S_IDLE) && word_vld && cap_en &&
                      ((word != last_q) || force_due);
    assign fill_hit = (state_q == S_FILL) && word_vld;
    assign wr_fire  = open_hit || (state_q == S_LEAD) || fill_hit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (open_hit) state_d = S_LEAD;
            S_LEAD: state_d = S_FILL;
            S_FILL: if (fill_hit && (slot_q == SLOT_LAST)) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and cluster bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
            last_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (open_hit) begin
                hold_q <= word;
                last_q <= word;
            end
            if (state_q == S_LEAD) begin
                slot_q <= SLOT_W'(1);
            end else if (fill_hit) begin
                slot_q <= slot_q + 1'b1;
                last_q <= word;
            end
        end
    end

    // registered write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= wr_fire;
            if (wr_fire) begin
                wr_addr <= addr;
            end
            unique case (state_q)
                S_IDLE: if (open_hit) wr_data <= stamp_ext;
                S_LEAD: wr_data <= hold_q;
                S_FILL: if (fill_hit) wr_data <= word;
                default: wr_data <= wr_data;
            endcase
        end
    end

endmodule

// File: rtl/cpk_cluster_packer_chk.sv
module cpk_cluster_packer_chk
    import cpk_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int EVENTS = 7,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              word_vld,
    input clu_state_e        state_q,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);

    localparam int CLU_WORDS = EVENTS + 1;
    localparam logic [TS_W:0] GAP_LIMIT = (TS_W+1)'((1 << TS_W) - 1);

    logic              stamp_slot;
    logic              seen_q;
    logic [ADDR_W-1:0] prev_q;
    logic [TS_W:0]     gap_cnt;

    assign stamp_slot = ((32'(wr_addr) % 32'(CLU_WORDS)) == 0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            prev_q  <= '0;
            gap_cnt <= '0;
        end else begin
            if (wr_en) begin
                seen_q <= 1'b1;
                prev_q <= wr_addr;
            end
            if (word_vld && !cap_en) begin
                gap_cnt <= '0;
            end else if (wr_en && stamp_slot) begin
                gap_cnt <= '0;
            end else if (word_vld && (gap_cnt <= GAP_LIMIT)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q) |-> (wr_addr == ADDR_W'(prev_q + 1'b1)));  // R8

    AST_STAMP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stamp_slot) |-> (state_q == S_LEAD));  // R5

    AST_LEAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stamp_slot) |=> (wr_en && !stamp_slot));  // R5

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GAP_LIMIT);  // R7

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && !cap_en) |=> !wr_en);  // R9

endmodule

bind cpk_cluster_packer cpk_cluster_packer_chk #(
    .TS_W   (TS_W),
    .EVENTS (EVENTS),
    .ADDR_W (ROW_BITS + WORD_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .word_vld (word_vld),
    .state_q  (state_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
);

// File: tb/test_cpk_cluster_packer.sv
module test_cpk_cluster_packer;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_W   = 16;
    localparam int TS_W       = 5;
    localparam int EVENTS     = 7;
    localparam int ROW_BITS   = 2;
    localparam int WORD_BITS  = 4;
    localparam int ADDR_W     = ROW_BITS + WORD_BITS;
    localparam int ADDR_SPAN  = 1 << ADDR_W;
    localparam int TS_SPAN    = 1 << TS_W;
    localparam int GAP_MAX    = TS_SPAN - 1;

    logic                clk;
    logic                rst_n;
    logic                tick;
    logic [SAMPLE_W-1:0] sample_in;
    logic [1:0]          mode;
    logic                cap_en;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [SAMPLE_W-1:0] wr_data;

    cpk_cluster_packer #(
        .SAMPLE_W  (SAMPLE_W),
        .TS_W      (TS_W),
        .EVENTS    (EVENTS),
        .ROW_BITS  (ROW_BITS),
        .WORD_BITS (WORD_BITS)
    ) i_cpk_cluster_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sample_in (sample_in),
        .mode      (mode),
        .cap_en    (cap_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_vec;
    int  n_bad;
    int  n_wr;
    bit  finished;

    logic [ADDR_W-1:0]   ea_q[$];
    logic [SAMPLE_W-1:0] ed_q[$];
    string               et_q[$];

    int                  m_ts, m_gap, m_fill, m_addr, lanes;
    logic [SAMPLE_W-1:0] m_last;
    logic [SAMPLE_W-1:0] cur [4];
    logic [15:0]         lfsr;
    string               ev_tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // packing per R2: channel c of lane k goes to bit c*N+k
    function automatic logic [SAMPLE_W-1:0] pack_ref(input int n);
        logic [SAMPLE_W-1:0] w;
        w = '0;
        for (int k = 0; k < n; k++)
            for (int c = 0; c < SAMPLE_W / n; c++)
                w[c*n + k] = cur[k][c];
        return w;
    endfunction

    task automatic push_exp(input logic [SAMPLE_W-1:0] d, input string tag);
        ea_q.push_back(ADDR_W'(m_addr));
        ed_q.push_back(d);
        et_q.push_back(tag);
        m_addr = (m_addr + 1) % ADDR_SPAN;
    endtask

    task automatic model_word(input logic [SAMPLE_W-1:0] w, input bit en);
        bit opened;
        opened = 0;
        if (m_fill > 0) begin
            push_exp(w, ev_tag);
            m_last = w;
            m_fill--;
        end else if (en && ((w != m_last) || (m_gap == GAP_MAX))) begin
            push_exp(SAMPLE_W'(m_ts), (w != m_last) ? "R3 R4" : "R3 R7");
            push_exp(w, ev_tag);
            m_last = w;
            m_fill = EVENTS - 1;
            opened = 1;
        end
        if (opened) m_gap = 1;
        else if (m_gap < GAP_MAX) m_gap++;
        m_ts = (m_ts + 1) % TS_SPAN;
    endtask

    task automatic send_word(input bit en, input int extra);
        for (int k = 0; k < lanes; k++) begin
            @(negedge clk);
            tick      = 1'b1;
            sample_in = cur[k];
            cap_en    = en;
            @(negedge clk);
            tick = 1'b0;
            repeat (extra) @(negedge clk);
        end
        model_word(pack_ref(lanes), en);
    endtask

    task automatic new_samples();
        for (int k = 0; k < 4; k++) begin
            lfsr   = lfsr_next(lfsr);
            cur[k] = lfsr ^ {lfsr[7:0], lfsr[15:8]};
        end
    endtask

    task automatic invert_samples();
        for (int k = 0; k < 4; k++) cur[k] = ~cur[k];
    endtask

    // monitor: compare every write with the model's stream
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            n_wr++;
            if (ea_q.size() == 0) begin
                chk(1'b0, "R6", "write with none expected", {16'h0, wr_data}, 32'h0);
            end else begin
                logic [ADDR_W-1:0]   ea;
                logic [SAMPLE_W-1:0] ed;
                string               et;
                ea = ea_q.pop_front();
                ed = ed_q.pop_front();
                et = et_q.pop_front();
                chk(wr_addr == ea, "R8", "write address", 32'(wr_addr), 32'(ea));
                chk(wr_data == ed, et, "write data", 32'(wr_data), 32'(ed));
            end
        end
    end

    task automatic run_mode(input logic [1:0] m);
        int snap;
        @(negedge clk);
        rst_n  = 1'b0;
        mode   = m;
        tick   = 1'b0;
        cap_en = 1'b0;
        repeat (3) @(negedge clk);
        m_ts = 0; m_gap = 1; m_fill = 0; m_addr = 0; m_last = '0;
        lanes  = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
        ev_tag = (m == 2'd0) ? "R5" : "R2 R5";
        rst_n  = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0 && wr_addr == '0 && wr_data == '0, "R1", "reset outputs",
            {wr_en, 9'h0, wr_addr, wr_data}, 32'h0);

        // random words, about half repeating the previous one
        for (int i = 0; i < 48; i++) begin
            lfsr = lfsr_next(lfsr);
            if (lfsr[0] || i == 0) new_samples();
            send_word(1'b1, lfsr[1] ? 1 : 0);
        end

        // settle: one guaranteed change then six repeats fills a cluster
        while (m_fill > 0) send_word(1'b1, 0);
        invert_samples();
        send_word(1'b1, 0);
        for (int i = 0; i < EVENTS - 1; i++) send_word(1'b1, 0);
        repeat (4) @(negedge clk);
        snap = n_wr;
        for (int i = 0; i < 20; i++) send_word(1'b1, 0);
        repeat (4) @(negedge clk);
        chk(n_wr == snap, "R6", "writes during constant input", 32'(n_wr - snap), 32'h0);

        // gap reached 7 after the fill; forcing happens on the 25th repeat
        snap = n_wr;
        for (int i = 0; i < 5; i++) send_word(1'b1, 0);
        repeat (4) @(negedge clk);
        chk(n_wr - snap == 2, "R7", "forced open writes", 32'(n_wr - snap), 32'd2);
        for (int i = 0; i < EVENTS - 1; i++) send_word(1'b1, 0);
        repeat (4) @(negedge clk);
        chk(n_wr - snap == EVENTS + 1, "R7", "forced cluster size",
            32'(n_wr - snap), 32'(EVENTS + 1));

        // disabled capture with changing data
        snap = n_wr;
        for (int i = 0; i < 20; i++) begin
            new_samples();
            send_word(1'b0, 0);
        end
        repeat (4) @(negedge clk);
        chk(n_wr == snap, "R9", "writes while disabled", 32'(n_wr - snap), 32'h0);

        // enabled again: mixed stream, disable mid-cluster, then long constant run
        for (int i = 0; i < 30; i++) begin
            lfsr = lfsr_next(lfsr);
            if (lfsr[2]) new_samples();
            send_word((i % 10) != 3, lfsr[3] ? 1 : 0);
        end
        for (int i = 0; i < 70; i++) send_word(1'b1, 0);
        repeat (6) @(negedge clk);
        chk(ea_q.size() == 0, "R5", "expected writes outstanding", 32'(ea_q.size()), 32'h0);
    endtask

    initial begin
        n_vec = 0; n_bad = 0; n_wr = 0; finished = 0;
        rst_n = 1'b0; tick = 1'b0; sample_in = '0; mode = 2'd0; cap_en = 1'b0;
        lfsr = 16'hACE1;
        for (int k = 0; k < 4; k++) cur[k] = '0;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 4; m++) run_mode(2'(m));
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule